// File: doc/BRIEF.md
# Decimal digit latch and seven-segment decoder

This block stores a four-bit decimal digit code and turns it into the seven segment-drive lines of a numeric display. The code sits in a register clocked by the system clock. While the hold input is low, the register loads the data input on every rising edge. While the hold input is high, the register keeps its value and the display stays frozen, whatever the data input does.

Two active-low controls act on the decoded pattern after the register:

- **Lamp check** lights every segment. It outranks everything else.
- **Blank** darkens every segment when lamp check is not active.

Both controls act without a clock edge. Neither changes the stored code, so the digit returns as soon as they are released. Codes above nine show nothing. The glyphs for six and nine have no tail bar.

Top module: `bcd_seg_latch`

## Requirements
- R1: An active-low asynchronous reset clears the stored code to 0. With both overrides inactive, the output then shows digit 0 (7'h3F) without waiting for a clock edge.
- R2: While hold_i is 0, each rising clock edge loads data_i (bit 0 is the LSB) into the stored code. The output shows the new digit after that edge.
- R3: While hold_i is 1, the stored code and the output do not change, whatever data_i does. When hold_i returns to 0, the next rising edge loads the value data_i has at that moment.
- R4: seg_o bit 0 drives segment a, and bits 1 to 6 drive segments b to g. A segment is lit when its bit is 1. The digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7C, 07, 7F, 67 (hex). Six has no top bar and nine has no bottom bar.
- R5: The stored codes 10 to 15 give seg_o = 7'h00.
- R6: test_ni = 0 gives seg_o = 7'h7F, whatever the values of blank_ni, hold_i and the stored code.
- R7: test_ni = 1 together with blank_ni = 0 gives seg_o = 7'h00.
- R8: A change on test_ni or blank_ni reaches seg_o within the same clock cycle, with no clock edge needed.
- R9: test_ni and blank_ni never change the stored code. The register keeps loading data_i while an override is active, and releasing the override shows the digit the register holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 4 | Digit code, bit 0 is the LSB |
| hold_i | input | 1 | 1 freezes the stored code, 0 lets it load |
| blank_ni | input | 1 | Active-low blank of all segments |
| test_ni | input | 1 | Active-low light-all lamp check |
| seg_o | output | 7 | Segment drives, bit 0 = a through bit 6 = g |

## Verification
The case hardest to reach from the ports is a stored code that changes while an override hides it. The display shows nothing of the change until the override is released.

To reach it, the bench holds lamp check or blank active, keeps hold low, and clocks in a new digit. It then releases the override and expects the new digit at once. It also moves data while hold is high, returns data to its old value, and then reopens the register. The expected pattern is set up so that a register that loaded data during the hold, or that failed to reload after it, shows a visibly different glyph.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int CODE_W  = 4;
  localparam int SEG_W   = 7;
  localparam int MAX_DIG = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  localparam seg_t SEG_ALL  = {SEG_W{1'b1}};
  localparam seg_t SEG_NONE = {SEG_W{1'b0}};
endpackage

// File: rtl/code_hold.sv
module code_hold
  import seg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t data_i,
  input  logic  hold_i,
  output code_t code_o
);
  code_t code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '0;
    else if (!hold_i) code_q <= data_i;
  end

  assign code_o = code_q;

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> code_q == $past(data_i));

  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(code_q));
endmodule

// File: rtl/digit_decode.sv
module digit_decode
  import seg_pkg::*;
(
  input  code_t code_i,
  output seg_t  pat_o
);
  // bit 0 = a ... bit 6 = g
  always_comb begin
    unique case (code_i)
      4'd0:    pat_o = 7'b0111111;
      4'd1:    pat_o = 7'b0000110;
      4'd2:    pat_o = 7'b1011011;
      4'd3:    pat_o = 7'b1001111;
      4'd4:    pat_o = 7'b1100110;
      4'd5:    pat_o = 7'b1101101;
      4'd6:    pat_o = 7'b1111100;  // tailless
      4'd7:    pat_o = 7'b0000111;
      4'd8:    pat_o = 7'b1111111;
      4'd9:    pat_o = 7'b1100111;  // tailless
      default: pat_o = SEG_NONE;
    endcase
  end
endmodule

// File: rtl/seg_override.sv
module seg_override
  import seg_pkg::*;
(
  input  seg_t pat_i,
  input  logic test_ni,
  input  logic blank_ni,
  output seg_t seg_o
);
  // lamp check > blank > decoded digit
  always_comb begin
    if (!test_ni)       seg_o = SEG_ALL;
    else if (!blank_ni) seg_o = SEG_NONE;
    else                seg_o = pat_i;
  end
endmodule

// File: rtl/bcd_seg_latch.sv
module bcd_seg_latch
  import seg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] data_i,
  input  logic              hold_i,
  input  logic              blank_ni,
  input  logic              test_ni,
  output logic [SEG_W-1:0]  seg_o
);
  code_t code_w;
  seg_t  pat_w;

  code_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .hold_i (hold_i),
    .code_o (code_w)
  );

  digit_decode u_dec (
    .code_i (code_w),
    .pat_o  (pat_w)
  );

  seg_override u_ovr (
    .pat_i    (pat_w),
    .test_ni  (test_ni),
    .blank_ni (blank_ni),
    .seg_o    (seg_o)
  );

  a_r5_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_ni && blank_ni && code_w > code_t'(MAX_DIG)) |-> seg_o == SEG_NONE);

  a_r4_glyph: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_ni && blank_ni && code_w <= code_t'(MAX_DIG)) |-> $countones(seg_o) >= 2);

  a_r6_lamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_ni |-> seg_o == SEG_ALL);

  a_r7_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_ni && !blank_ni) |-> seg_o == SEG_NONE);
endmodule

// File: tb/sim_bcd_seg_latch.sv
module sim_bcd_seg_latch;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] data_i = 4'd0;
  logic       hold_i = 1'b0;
  logic       blank_ni = 1'b1;
  logic       test_ni = 1'b1;
  logic [6:0] seg_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // {code, expected segments}, bit 0 = a
  localparam logic [10:0] VEC [16] = '{
    {4'd0,  7'h3F}, {4'd1,  7'h06}, {4'd2,  7'h5B}, {4'd3,  7'h4F},
    {4'd4,  7'h66}, {4'd5,  7'h6D}, {4'd6,  7'h7C}, {4'd7,  7'h07},
    {4'd8,  7'h7F}, {4'd9,  7'h67}, {4'd10, 7'h00}, {4'd11, 7'h00},
    {4'd12, 7'h00}, {4'd13, 7'h00}, {4'd14, 7'h00}, {4'd15, 7'h00}
  };

  bcd_seg_latch u0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .hold_i   (hold_i),
    .blank_ni (blank_ni),
    .test_ni  (test_ni),
    .seg_o    (seg_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk(input string rid, input logic [6:0] exp);
    total++;
    if (seg_o !== exp) begin
      bad++;
      $display("FAIL %s: seg_o=%h expected=%h at %0t", rid, seg_o, exp, $time);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R1 in reset", 7'h3F);
    rst_ni = 1'b1;
    data_i = 4'd0;
    tick();
    chk("R1 after reset", 7'h3F);

    // R4, R5: every code through the table
    for (int i = 0; i < 16; i++) begin
      data_i = VEC[i][10:7];
      tick();
      chk((i < 10) ? "R4 digit" : "R5 invalid", VEC[i][6:0]);
    end

    // R6, R7, R8: override combinations, no clock edge between
    data_i = 4'd3;
    tick();
    chk("R2 load 3", 7'h4F);
    test_ni = 1'b0; blank_ni = 1'b1; #1 chk("R6 lamp", 7'h7F);
    test_ni = 1'b0; blank_ni = 1'b0; #1 chk("R6 lamp over blank", 7'h7F);
    test_ni = 1'b1; blank_ni = 1'b0; #1 chk("R7 blank", 7'h00);
    test_ni = 1'b1; blank_ni = 1'b1; #1 chk("R8 release", 7'h4F);

    // R6 over an invalid code while held
    data_i = 4'd12;
    tick();
    hold_i = 1'b1;
    test_ni = 1'b0; #1 chk("R6 lamp invalid held", 7'h7F);
    test_ni = 1'b1; #1 chk("R5 invalid back", 7'h00);
    hold_i = 1'b0;

    // R9: register keeps loading under each override
    test_ni = 1'b0;
    data_i = 4'd5;
    tick();
    chk("R6 lamp during load", 7'h7F);
    test_ni = 1'b1; #1 chk("R9 after lamp", 7'h6D);
    blank_ni = 1'b0;
    data_i = 4'd6;
    tick();
    chk("R7 blank during load", 7'h00);
    blank_ni = 1'b1; #1 chk("R9 after blank", 7'h7C);

    // R3: data moves while held, returns, then register reopens
    data_i = 4'd2;
    tick();
    chk("R2 load 2", 7'h5B);
    hold_i = 1'b1;
    data_i = 4'd8;
    tick();
    chk("R3 held vs 8", 7'h5B);
    data_i = 4'd7;
    tick();
    tick();
    chk("R3 held vs 7", 7'h5B);
    data_i = 4'd2;
    hold_i = 1'b0;
    tick();
    chk("R3 reopen same", 7'h5B);
    data_i = 4'd7;
    tick();
    chk("R3 reopen new", 7'h07);

    // R1: asynchronous reset mid-run, with hold set
    hold_i = 1'b1;
    rst_ni = 1'b0;
    #1 chk("R1 async clear", 7'h3F);
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 held after reset", 7'h3F);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule